// File: doc/BRIEF.md
# Three-Level Page Table Walker with Bus-Error Faults

This block resolves a 32-bit virtual address to a physical page address by walking a context table and up to three levels of page tables held in memory. A request carries the virtual address, the context table pointer and the context number. The walker then issues 32-bit descriptor reads one after another over a simple memory port. The port holds each read until a response arrives, and the response returns data together with an error flag.

Each descriptor holds a 2-bit entry type in its low bits. A table descriptor sends the walk down one level. A page descriptor ends the walk with a translation. Any other entry ends the walk with a translation-error fault word. A bus error on any descriptor read also ends the walk as a translation error, tagged with the level being read. It is never reported as an access fault at the descriptor's address. The walker handles one request at a time. A single-cycle done pulse carries the result.

Top module: `xlat_walker`

## Requirements
- R1: After reset, busy, done and mem_req are all low.
- R2: The first read of a walk goes to address (context pointer × 16) + (context number × 4), computed on 36 bits.
- R3: After a table descriptor is read at level L (0..2), the next read goes to ((descriptor with bits 1:0 cleared) × 16) + index × 4. The index is VA[31:24] for level 1, VA[23:18] for level 2 and VA[17:12] for level 3.
- R4: Entry type 1 (bits 1:0 = 01) at levels 0 to 2 makes the walker issue exactly one more read, at the next level.
- R5: Entry type 2 (bits 1:0 = 10) at level L ends the walk with done_fault low and done_fsr zero. done_paddr is then descriptor bits 31:8 placed at physical bits 35:12, with the low 32, 24, 18 or 12 bits (for L = 0, 1, 2, 3) taken from the virtual address instead.
- R6: A read answered with mem_rerr high at level L ends the walk with no further read. done_fault is high, done_paddr is zero, and done_fsr holds L in bits 9:8, code 4 in bits 4:2 and zeros elsewhere. The data returned with the error has no effect.
- R7: Entry type 0 or 3 at any level L, and entry type 1 at level 3, end the walk with the same fault word as R6 for level L.
- R8: While mem_req is high and no response has arrived, mem_req stays high and mem_addr stays stable. Only one read is outstanding at a time.
- R9: busy rises in the cycle after a request is accepted and stays high through a done pulse exactly one cycle long, then falls. A request presented while busy is ignored and does not change the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ctp | input | 32 | Context table pointer |
| req_ctx | input | 8 | Context number |
| busy | output | 1 | Walk in progress, including the done cycle |
| done | output | 1 | One-cycle result strobe |
| done_fault | output | 1 | Result is a fault |
| done_paddr | output | 36 | Physical address on success, zero on fault |
| done_fsr | output | 10 | Fault status on fault, zero on success |
| mem_req | output | 1 | Descriptor read request, held until response |
| mem_addr | output | 36 | Descriptor read address |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 32 | Descriptor data |
| mem_rerr | input | 1 | Read response is a bus error |

## Verification
The hardest case to reach from the ports is a bus error or a bad entry at the last level. To get there, three table descriptors must each point exactly at the next table, so that the walk reaches level 3 at the address the bench expects. The bench builds every walk as a chain. It picks a stopping level and an ending kind, generates table descriptors with random pointers for the levels above, and answers each read in sequence. Before answering, it compares the requested address with its own prediction. Random response delays and spurious requests during a walk exercise request holding and request rejection.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam logic [2:0] XLAT_ERR_CODE = 3'd4;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_TABLE   = 2'd1,
    ET_PAGE    = 2'd2,
    ET_RSVD    = 2'd3
  } entry_type_e;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_READ,
    WS_FIN
  } walk_state_e;

  // fault status: level in [9:8], error code in [4:2]
  function automatic logic [9:0] fault_word(input logic [1:0] lvl);
    return {lvl, 3'b000, XLAT_ERR_CODE, 2'b00};
  endfunction

endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 36,
  parameter int unsigned CTP_W  = 32,
  parameter int unsigned CTX_W  = 8,
  parameter int unsigned DESC_W = 32
) (
  input  logic [CTP_W-1:0]      ctp,
  input  logic [CTX_W-1:0]      ctx,
  input  logic [VA_W-1:VA_W-20] va_hi,
  input  logic [DESC_W-1:2]     ptr_field,
  input  logic [1:0]            next_lvl,
  output logic [PA_W-1:0]       root_addr,
  output logic [PA_W-1:0]       next_addr
);
  localparam int unsigned IDX1_LO = VA_W - 8;
  localparam int unsigned IDX2_LO = IDX1_LO - 6;
  localparam int unsigned IDX3_LO = IDX2_LO - 6;

  function automatic logic [PA_W-1:0] table_base(input logic [DESC_W-1:2] p);
    return PA_W'({p, 2'b00}) << 4;
  endfunction

  function automatic logic [PA_W-1:0] level_offset(input logic [1:0] lvl,
                                                   input logic [VA_W-1:VA_W-20] v);
    case (lvl)
      2'd1:    return PA_W'(v[VA_W-1:IDX1_LO]) << 2;
      2'd2:    return PA_W'(v[IDX1_LO-1:IDX2_LO]) << 2;
      2'd3:    return PA_W'(v[IDX2_LO-1:IDX3_LO]) << 2;
      default: return '0;
    endcase
  endfunction

  always_comb begin
    root_addr = (PA_W'(ctp) << 4) + (PA_W'(ctx) << 2);
    next_addr = table_base(ptr_field) + level_offset(next_lvl, va_hi);
  end

endmodule

// File: rtl/xlat_desc_dec.sv
module xlat_desc_dec #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 36,
  parameter int unsigned DESC_W = 32
) (
  input  logic [1:0]        entry_type,
  input  logic [DESC_W-9:0] frame_num,
  input  logic [1:0]        lvl,
  input  logic [VA_W-1:0]   va,
  output logic              is_table,
  output logic              is_page,
  output logic              is_bad,
  output logic [PA_W-1:0]   page_pa
);
  import xlat_pkg::*;

  localparam int unsigned PAGE_SH = 12;

  function automatic logic [PA_W-1:0] offset_mask(input logic [1:0] l);
    int unsigned w;
    case (l)
      2'd0:    w = VA_W;
      2'd1:    w = VA_W - 8;
      2'd2:    w = VA_W - 14;
      default: w = VA_W - 20;
    endcase
    return (PA_W'(1) << w) - PA_W'(1);
  endfunction

  entry_type_e     et;
  logic [PA_W-1:0] frame;
  logic [PA_W-1:0] mask;

  always_comb begin
    et       = entry_type_e'(entry_type);
    is_table = (et == ET_TABLE) && (lvl != 2'd3);
    is_page  = (et == ET_PAGE);
    is_bad   = !is_table && !is_page;
    frame    = PA_W'(frame_num) << PAGE_SH;
    mask     = offset_mask(lvl);
    page_pa  = (frame & ~mask) | (PA_W'(va) & mask);
  end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 36,
  parameter int unsigned CTP_W  = 32,
  parameter int unsigned CTX_W  = 8,
  parameter int unsigned DESC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [CTP_W-1:0]  req_ctp,
  input  logic [CTX_W-1:0]  req_ctx,
  output logic              busy,
  output logic              done,
  output logic              done_fault,
  output logic [PA_W-1:0]   done_paddr,
  output logic [9:0]        done_fsr,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [DESC_W-1:0] mem_rdata,
  input  logic              mem_rerr
);
  import xlat_pkg::*;

  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned LVL_W   = $clog2(NUM_LVL);

  walk_state_e       state_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   addr_q;
  logic              res_fault_q;
  logic [PA_W-1:0]   res_pa_q;
  logic [9:0]        res_fsr_q;

  logic [PA_W-1:0]   root_addr, next_addr, page_pa;
  logic              is_table, is_page, is_bad;

  // named events for the checker
  logic accept, rsp_take, rsp_bus_err, step_down, walk_hit, walk_bad;
  logic [LVL_W-1:0] next_lvl;

  xlat_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .CTP_W(CTP_W), .CTX_W(CTX_W), .DESC_W(DESC_W)
  ) addr_i (
    .ctp       (req_ctp),
    .ctx       (req_ctx),
    .va_hi     (va_q[VA_W-1:VA_W-20]),
    .ptr_field (mem_rdata[DESC_W-1:2]),
    .next_lvl  (next_lvl),
    .root_addr (root_addr),
    .next_addr (next_addr)
  );

  xlat_desc_dec #(
    .VA_W(VA_W), .PA_W(PA_W), .DESC_W(DESC_W)
  ) dec_i (
    .entry_type (mem_rdata[1:0]),
    .frame_num  (mem_rdata[DESC_W-1:8]),
    .lvl        (lvl_q),
    .va         (va_q),
    .is_table   (is_table),
    .is_page    (is_page),
    .is_bad     (is_bad),
    .page_pa    (page_pa)
  );

  always_comb begin
    next_lvl    = lvl_q + LVL_W'(1);
    accept      = req_valid && (state_q == WS_IDLE);
    rsp_take    = (state_q == WS_READ) && mem_rvalid;
    rsp_bus_err = rsp_take && mem_rerr;
    step_down   = rsp_take && !mem_rerr && is_table;
    walk_hit    = rsp_take && !mem_rerr && is_page;
    walk_bad    = rsp_take && !mem_rerr && is_bad;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= WS_IDLE;
      lvl_q       <= '0;
      va_q        <= '0;
      addr_q      <= '0;
      res_fault_q <= 1'b0;
      res_pa_q    <= '0;
      res_fsr_q   <= '0;
    end else begin
      case (state_q)
        WS_IDLE: begin
          if (accept) begin
            va_q    <= req_vaddr;
            addr_q  <= root_addr;
            lvl_q   <= '0;
            state_q <= WS_READ;
          end
        end
        WS_READ: begin
          if (step_down) begin
            lvl_q  <= next_lvl;
            addr_q <= next_addr;
          end else if (walk_hit) begin
            res_fault_q <= 1'b0;
            res_pa_q    <= page_pa;
            res_fsr_q   <= '0;
            state_q     <= WS_FIN;
          end else if (rsp_bus_err || walk_bad) begin
            res_fault_q <= 1'b1;
            res_pa_q    <= '0;
            res_fsr_q   <= fault_word(lvl_q);
            state_q     <= WS_FIN;
          end
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  always_comb begin
    busy       = (state_q != WS_IDLE);
    done       = (state_q == WS_FIN);
    mem_req    = (state_q == WS_READ);
    mem_addr   = addr_q;
    done_fault = res_fault_q;
    done_paddr = res_pa_q;
    done_fsr   = res_fsr_q;
  end

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
  parameter int unsigned PA_W = 36
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            busy,
  input logic            done,
  input logic            done_fault,
  input logic [9:0]      done_fsr,
  input logic            mem_req,
  input logic [PA_W-1:0] mem_addr,
  input logic            mem_rvalid,
  input logic            mem_rerr,
  input logic            step_down
);

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || done) |-> busy);

  // R9
  accept_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R6
  bus_err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rvalid && mem_rerr |=> done && done_fault && !mem_req);

  // R4
  descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_down |=> mem_req && !done);

  // R7
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_fault |-> done_fsr[4:2] == 3'd4 && done_fsr[7:5] == 3'd0 && done_fsr[1:0] == 2'd0);

  // R5
  hit_fsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_fault |-> done_fsr == 10'd0);

endmodule

bind xlat_walker xlat_walker_chk #(.PA_W(PA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .busy       (busy),
  .done       (done),
  .done_fault (done_fault),
  .done_fsr   (done_fsr),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .mem_rerr   (mem_rerr),
  .step_down  (step_down)
);

// File: tb/xlat_walker_tb_top.sv
module xlat_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_ctp = '0;
  logic [7:0]  req_ctx = '0;
  logic        busy, done, done_fault, mem_req;
  logic [35:0] done_paddr, mem_addr;
  logic [9:0]  done_fsr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_rerr = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  xlat_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ctp(req_ctp), .req_ctx(req_ctx), .busy(busy), .done(done),
    .done_fault(done_fault), .done_paddr(done_paddr), .done_fsr(done_fsr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_rerr(mem_rerr)
  );

  localparam logic [63:0] M36 = 64'hF_FFFF_FFFF;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // expected-value models written from the requirements
  function automatic logic [63:0] m_root(input logic [31:0] ctp, input logic [7:0] ctx);
    return ((64'(ctp) * 16) + (64'(ctx) * 4)) & M36;
  endfunction

  function automatic logic [63:0] m_next(input logic [31:0] d, input logic [31:0] va, input int lvl);
    logic [63:0] idx;
    case (lvl)
      1: idx = 64'(va >> 24) & 64'hFF;
      2: idx = 64'(va >> 18) & 64'h3F;
      default: idx = 64'(va >> 12) & 64'h3F;
    endcase
    return ((64'(d >> 2) * 64) + idx * 4) & M36;
  endfunction

  function automatic logic [63:0] m_page(input logic [31:0] d, input logic [31:0] va, input int lvl);
    int keep;
    logic [63:0] lowpart;
    keep = (lvl == 0) ? 32 : (lvl == 1) ? 24 : (lvl == 2) ? 18 : 12;
    lowpart = 64'(va) % (64'd1 << keep);
    return ((64'(d >> 8) * 4096) / (64'd1 << keep) * (64'd1 << keep) + lowpart) & M36;
  endfunction

  function automatic logic [63:0] m_fsr(input int lvl);
    return 64'(lvl * 256 + 16);
  endfunction

  // kind: 0 page entry, 1 bus error, 2 type 0, 3 type 3, 4 table at level 3
  task automatic run_walk(input logic [31:0] va, input logic [31:0] ctp, input logic [7:0] ctx,
                          input int stop, input int kind, input bit poke);
    logic [31:0] desc [4];
    logic        err  [4];
    logic [63:0] addr [4];
    logic [63:0] exp_pa, exp_fsr;
    bit          exp_fault;
    string       ftag;
    addr[0] = m_root(ctp, ctx);
    for (int k = 0; k <= stop; k++) begin
      err[k] = 1'b0;
      if (k < stop) begin
        desc[k] = {$urandom() >> 2, 2'b01};
        addr[k+1] = m_next(desc[k], va, k + 1);
      end else begin
        case (kind)
          0: desc[k] = {$urandom() >> 2, 2'b10};
          1: begin desc[k] = $urandom(); err[k] = 1'b1; end
          2: desc[k] = {$urandom() >> 2, 2'b00};
          3: desc[k] = {$urandom() >> 2, 2'b11};
          default: desc[k] = {$urandom() >> 2, 2'b01};
        endcase
      end
    end
    exp_fault = (kind != 0);
    exp_pa    = exp_fault ? 64'd0 : m_page(desc[stop], va, stop);
    exp_fsr   = exp_fault ? m_fsr(stop) : 64'd0;
    ftag      = (kind == 0) ? "R5" : (kind == 1) ? "R6" : "R7";

    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_ctp = ctp; req_ctx = ctx;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
    for (int k = 0; k <= stop; k++) begin
      chk(mem_req === 1'b1, "R4 read issued", 64'(mem_req), 64'd1);
      chk(64'(mem_addr) === addr[k], (k == 0) ? "R2 root addr" : "R3 level addr",
          64'(mem_addr), addr[k]);
      for (int d = 0; d < int'($urandom() % 4); d++) begin
        if (poke) begin
          req_valid = 1'b1; req_vaddr = $urandom(); req_ctp = $urandom(); req_ctx = 8'($urandom());
        end
        @(negedge clk);
        chk(mem_req === 1'b1 && 64'(mem_addr) === addr[k], "R8 hold", 64'(mem_addr), addr[k]);
      end
      req_valid  = 1'b0;
      mem_rvalid = 1'b1; mem_rdata = desc[k]; mem_rerr = err[k];
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = $urandom(); mem_rerr = 1'b0;
    end
    chk(done === 1'b1, "R9 done pulse", 64'(done), 64'd1);
    chk(mem_req === 1'b0, {ftag, " no further read"}, 64'(mem_req), 64'd0);
    chk(done_fault === exp_fault, {ftag, " fault flag"}, 64'(done_fault), 64'(exp_fault));
    chk(64'(done_paddr) === exp_pa, {ftag, " paddr"}, 64'(done_paddr), exp_pa);
    chk(64'(done_fsr) === exp_fsr, {ftag, " fsr"}, 64'(done_fsr), exp_fsr);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R9 single done, idle", {62'd0, done, busy}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R1 reset state",
        {61'd0, busy, done, mem_req}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R1 idle after reset", 64'(busy), 64'd0);

    // directed: every level with every ending
    for (int l = 0; l < 4; l++) begin
      for (int kd = 0; kd < 4; kd++)
        run_walk($urandom(), $urandom(), 8'($urandom()), l, kd, 1'b0);
    end
    run_walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'hFF, 3, 4, 1'b0);  // R7 table at last level
    run_walk(32'hFFFF_F123, 32'hFFFF_FFFF, 8'hFF, 3, 0, 1'b1);  // R2 carry, R5 level 3
    run_walk(32'h0000_0000, 32'h0, 8'h0, 3, 1, 1'b1);           // R6 level 3 bus error

    // constrained random walks
    for (int i = 0; i < 300; i++) begin
      int st;
      st = int'($urandom() % 4);
      run_walk($urandom(), $urandom(), 8'($urandom()), st,
               int'($urandom() % ((st == 3) ? 5 : 4)), 1'($urandom()));
    end
    finish_run();
  end

endmodule